// File: doc/BRIEF.md
# Multiplexed Address/Data External Memory Bus Controller

This block sits between the data-side request port of a small processor and two memories: an internal SRAM reached through a simple strobe interface, and an external SRAM reached over pins. The external pins are an 8-bit port that carries both the low address byte and the data, a separate 8-bit port for the high address byte, and three control lines. The control lines are an address latch enable (ALE), an active-low read strobe and an active-low write strobe. An external transparent latch captures the low address byte while ALE is high and holds it after ALE falls. The controller works out from the address alone whether an access is internal or external. It then runs every access through the same fixed three-cycle sequence.

An enable input gates the whole interface. While the interface is enabled, the controller owns the values and directions of all its dedicated pins. The address, data and ALE lines show activity on every access, internal ones included. The read and write strobes move only for external accesses. While the interface is disabled, every pin takes the ordinary port value and direction supplied from outside. Requests whose addresses fall beyond the internal boundary then touch neither memory, and they can never alias into internal SRAM.

Top module: `xbus_ctrl`

## Requirements
- R1: A request is accepted only while `req_ready` is high (idle). The access then runs for exactly three cycles: ALE high in the first, and ALE low in the second and third. `rsp_valid` pulses for one cycle in the cycle after the third, when `req_ready` returns high. `req_ready` is low during the three cycles.
- R2: While enabled, the low address byte is driven on `ad_o` with `ad_oe` all ones in both the first and the second cycle, so the byte is valid and unchanged when ALE falls.
- R3: While enabled, `ah_o` carries the high address byte with `ah_oe` all ones in all three cycles of an access.
- R4: An address greater than parameter `INT_LAST` is external, and any other address is internal. `int_we` or `int_re` is asserted only in the third cycle of an internal write or read, and never for an external address.
- R5: On an enabled external write, the third cycle has the write strobe (`ctl_o[2]`) low, the read strobe (`ctl_o[1]`) high, and `ad_o` equal to the write data with `ad_oe` all ones. The external device stores that byte.
- R6: On an enabled external read, the third cycle has the read strobe low, the write strobe high and `ad_oe` all zero. `rsp_rdata` is the value on `ad_i` at the end of that cycle.
- R7: On an enabled internal access, ALE and the address bytes behave as in R1 to R3. A write also drives its data on `ad_o` in the third cycle. Both strobes stay high throughout, and a read returns `int_rdata`.
- R8: While disabled, every pin follows the port settings: `ad_o`/`ad_oe` = `port_ad_val`/`port_ad_dir`, `ah_o`/`ah_oe` = `port_ah_val`/`port_ah_dir`, and `ctl_o`/`ctl_oe` = `port_ctl_val`/`port_ctl_dir`. The pull-ups are `ad_pu` = `port_ad_val & ~port_ad_dir`.
- R9: While disabled, an access to an external address asserts neither `int_we` nor `int_re`. A read returns 8'h00, a write changes neither memory, and internal addresses still work.
- R10: While enabled, `ad_pu` equals `port_ad_val` bit for bit.
- R11: While enabled and idle, `ad_oe` is all zero, `ctl_o` is 3'b110 (ALE low, both strobes high) and `ctl_oe` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Interface enable |
| req_valid | input | 1 | Access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Idle, request can be taken |
| rsp_valid | output | 1 | Access completed (one-cycle pulse) |
| rsp_rdata | output | 8 | Read data |
| int_addr | output | 16 | Internal SRAM address |
| int_wdata | output | 8 | Internal SRAM write data |
| int_we | output | 1 | Internal SRAM write strobe |
| int_re | output | 1 | Internal SRAM read strobe |
| int_rdata | input | 8 | Internal SRAM read data |
| ad_i | input | 8 | Multiplexed port input value |
| ad_o | output | 8 | Multiplexed port output value |
| ad_oe | output | 8 | Multiplexed port output enables |
| ad_pu | output | 8 | Multiplexed port pull-up enables |
| ah_o | output | 8 | High-address port output value |
| ah_oe | output | 8 | High-address port output enables |
| ctl_o | output | 3 | Control pins: [0] ALE, [1] read strobe (low active), [2] write strobe (low active) |
| ctl_oe | output | 3 | Control pin output enables |
| port_ad_val | input | 8 | Normal port value, multiplexed port |
| port_ad_dir | input | 8 | Normal port direction, multiplexed port (1 = out) |
| port_ah_val | input | 8 | Normal port value, high-address port |
| port_ah_dir | input | 8 | Normal port direction, high-address port |
| port_ctl_val | input | 3 | Normal port value, control pins |
| port_ctl_dir | input | 3 | Normal port direction, control pins |

## Verification
The bench builds the block with its defaults: a 16-bit address, an 8-bit multiplexed port and `INT_LAST` = 16'h10FF. The addresses on either side of the boundary (16'h10FF and 16'h1100) can therefore be reached directly, along with a high byte of 8'hFF. The behavioural stubs index their arrays by the low address byte, so a disabled external access at 16'h2042 lands on the same index as internal 16'h0042. That collision exposes any aliasing. A read strobe that is mis-gated shows up through the fill value that the stub drives when the strobe is high.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  // Access sequencing phases
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ALE  = 2'd1,
    PH_HOLD = 2'd2,
    PH_DATA = 2'd3
  } xb_phase_e;

  // Attributes of the access in flight, captured at acceptance
  typedef struct packed {
    logic we;
    logic ext;
    logic en;
  } xb_kind_t;

  // Control pin indices
  localparam int CTL_ALE = 0;
  localparam int CTL_RDN = 1;
  localparam int CTL_WRN = 2;
  localparam int CTL_W   = 3;

  // Address classification: strictly above the last internal address is external
  function automatic logic addr_is_ext(input logic [31:0] addr, input logic [31:0] last);
    return addr > last;
  endfunction

  // Pull-up rule for a normal port line: only inputs with port bit one
  function automatic logic port_pullup(input logic val, input logic dir);
    return val & ~dir;
  endfunction

endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter int unsigned INT_LAST = 32'h10FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] rd_sample,
  output xb_phase_e     phase,
  output xb_kind_t      kind,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);

  // Named events for the checks below
  logic acc_start;
  logic acc_end;

  assign acc_start = req_valid && (phase == PH_IDLE);
  assign acc_end   = (phase == PH_DATA);
  assign req_ready = (phase == PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      kind      <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc_end;
      unique case (phase)
        PH_IDLE: begin
          if (acc_start) begin
            phase    <= PH_ALE;
            addr_q   <= req_addr;
            wdata_q  <= req_wdata;
            kind.we  <= req_we;
            kind.en  <= en;
            kind.ext <= addr_is_ext(32'(req_addr), INT_LAST);
          end
        end
        PH_ALE:  phase <= PH_HOLD;
        PH_HOLD: phase <= PH_DATA;
        PH_DATA: begin
          phase <= PH_IDLE;
          if (!kind.we) rsp_rdata <= rd_sample;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R1: fixed three-phase order, then a single response pulse
  p_ale_then_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ALE) |=> (phase == PH_HOLD));
  p_hold_then_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HOLD) |=> (phase == PH_DATA));
  p_data_then_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_end |=> (rsp_valid && req_ready));
  p_start_leaves_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |=> (phase == PH_ALE) && !rsp_valid);

endmodule

// File: rtl/xbus_decode.sv
module xbus_decode
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  xb_phase_e     phase,
  input  xb_kind_t      kind,
  input  logic [AW-1:0] addr_q,
  input  logic [DW-1:0] wdata_q,
  input  logic [DW-1:0] ad_i,
  input  logic [DW-1:0] int_rdata,
  output logic          ale_b,
  output logic          rd_n_b,
  output logic          wr_n_b,
  output logic          ad_oe_b,
  output logic [DW-1:0] ad_data_b,
  output logic          int_we,
  output logic          int_re,
  output logic [DW-1:0] rd_sample
);

  logic addr_ph;
  logic data_ph;
  logic ext_live;
  logic int_hit;

  assign addr_ph  = (phase == PH_ALE) || (phase == PH_HOLD);
  assign data_ph  = (phase == PH_DATA);
  assign ext_live = kind.en && kind.ext;
  assign int_hit  = !kind.ext;

  // Bus-level signals before pin override
  assign ale_b     = (phase == PH_ALE);
  assign rd_n_b    = !(data_ph && ext_live && !kind.we);
  assign wr_n_b    = !(data_ph && ext_live && kind.we);
  assign ad_oe_b   = addr_ph || (data_ph && kind.we);
  assign ad_data_b = data_ph ? wdata_q : addr_q[DW-1:0];

  // Internal SRAM strobes: only for addresses at or below the boundary
  assign int_we = data_ph && int_hit && kind.we;
  assign int_re = data_ph && int_hit && !kind.we;

  // Read source: internal array, external pins, or zero when unmapped
  always_comb begin
    if (int_hit)      rd_sample = int_rdata;
    else if (kind.en) rd_sample = ad_i;
    else              rd_sample = '0;
  end

  // R5: the two strobes are never active together
  p_strobe_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n_b && !wr_n_b));
  // R1: a strobe is only active while ALE is low
  p_strobe_ale_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n_b || !wr_n_b) |-> !ale_b);

endmodule

// File: rtl/xbus_pinmux.sv
module xbus_pinmux
  import xbus_pkg::*;
#(
  parameter int DW = 8,
  parameter int HW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ale_b,
  input  logic             rd_n_b,
  input  logic             wr_n_b,
  input  logic             ad_oe_b,
  input  logic [DW-1:0]    ad_data_b,
  input  logic [HW-1:0]    ah_b,
  input  logic [DW-1:0]    port_ad_val,
  input  logic [DW-1:0]    port_ad_dir,
  input  logic [HW-1:0]    port_ah_val,
  input  logic [HW-1:0]    port_ah_dir,
  input  logic [CTL_W-1:0] port_ctl_val,
  input  logic [CTL_W-1:0] port_ctl_dir,
  output logic [DW-1:0]    ad_o,
  output logic [DW-1:0]    ad_oe,
  output logic [DW-1:0]    ad_pu,
  output logic [HW-1:0]    ah_o,
  output logic [HW-1:0]    ah_oe,
  output logic [CTL_W-1:0] ctl_o,
  output logic [CTL_W-1:0] ctl_oe
);

  logic [CTL_W-1:0] ctl_b;

  assign ctl_b[CTL_ALE] = ale_b;
  assign ctl_b[CTL_RDN] = rd_n_b;
  assign ctl_b[CTL_WRN] = wr_n_b;

  // Multiplexed address/data lines
  for (genvar i = 0; i < DW; i++) begin : g_ad
    assign ad_o[i]  = en ? ad_data_b[i] : port_ad_val[i];
    assign ad_oe[i] = en ? ad_oe_b      : port_ad_dir[i];
    assign ad_pu[i] = en ? port_ad_val[i] : port_pullup(port_ad_val[i], port_ad_dir[i]);
  end

  // High address lines: always outputs while enabled
  for (genvar j = 0; j < HW; j++) begin : g_ah
    assign ah_o[j]  = en ? ah_b[j] : port_ah_val[j];
    assign ah_oe[j] = en | port_ah_dir[j];
  end

  // Control lines
  for (genvar k = 0; k < CTL_W; k++) begin : g_ctl
    assign ctl_o[k]  = en ? ctl_b[k] : port_ctl_val[k];
    assign ctl_oe[k] = en | port_ctl_dir[k];
  end

  // R2: low address byte stable and driven across the falling ALE edge
  p_addr_at_ale_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $fell(ctl_o[CTL_ALE])) |-> ($stable(ad_o) && (&ad_oe)));

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter int unsigned INT_LAST = 32'h10FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             req_valid,
  input  logic             req_we,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_ready,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic [AW-1:0]    int_addr,
  output logic [DW-1:0]    int_wdata,
  output logic             int_we,
  output logic             int_re,
  input  logic [DW-1:0]    int_rdata,
  input  logic [DW-1:0]    ad_i,
  output logic [DW-1:0]    ad_o,
  output logic [DW-1:0]    ad_oe,
  output logic [DW-1:0]    ad_pu,
  output logic [AW-DW-1:0] ah_o,
  output logic [AW-DW-1:0] ah_oe,
  output logic [2:0]       ctl_o,
  output logic [2:0]       ctl_oe,
  input  logic [DW-1:0]    port_ad_val,
  input  logic [DW-1:0]    port_ad_dir,
  input  logic [AW-DW-1:0] port_ah_val,
  input  logic [AW-DW-1:0] port_ah_dir,
  input  logic [2:0]       port_ctl_val,
  input  logic [2:0]       port_ctl_dir
);

  localparam int HW = AW - DW;

  xb_phase_e     phase;
  xb_kind_t      kind;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rd_sample;
  logic          ale_b;
  logic          rd_n_b;
  logic          wr_n_b;
  logic          ad_oe_b;
  logic [DW-1:0] ad_data_b;

  xbus_seq #(.AW(AW), .DW(DW), .INT_LAST(INT_LAST)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_sample (rd_sample),
    .phase     (phase),
    .kind      (kind),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  xbus_decode #(.AW(AW), .DW(DW)) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .kind      (kind),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .ad_i      (ad_i),
    .int_rdata (int_rdata),
    .ale_b     (ale_b),
    .rd_n_b    (rd_n_b),
    .wr_n_b    (wr_n_b),
    .ad_oe_b   (ad_oe_b),
    .ad_data_b (ad_data_b),
    .int_we    (int_we),
    .int_re    (int_re),
    .rd_sample (rd_sample)
  );

  xbus_pinmux #(.DW(DW), .HW(HW)) u_pinmux (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .ale_b        (ale_b),
    .rd_n_b       (rd_n_b),
    .wr_n_b       (wr_n_b),
    .ad_oe_b      (ad_oe_b),
    .ad_data_b    (ad_data_b),
    .ah_b         (addr_q[AW-1:DW]),
    .port_ad_val  (port_ad_val),
    .port_ad_dir  (port_ad_dir),
    .port_ah_val  (port_ah_val),
    .port_ah_dir  (port_ah_dir),
    .port_ctl_val (port_ctl_val),
    .port_ctl_dir (port_ctl_dir),
    .ad_o         (ad_o),
    .ad_oe        (ad_oe),
    .ad_pu        (ad_pu),
    .ah_o         (ah_o),
    .ah_oe        (ah_oe),
    .ctl_o        (ctl_o),
    .ctl_oe       (ctl_oe)
  );

  assign int_addr  = addr_q;
  assign int_wdata = wdata_q;

  // R7: internal accesses never move the pin strobes
  p_int_no_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && kind.en && !kind.ext && (phase != PH_IDLE)) |-> (ctl_o[1] && ctl_o[2]));
  // R9: an unmapped access while disabled never reaches internal SRAM
  p_no_alias_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!kind.en && kind.ext && (phase != PH_IDLE)) |-> (!int_we && !int_re));
  // R4: internal strobes only in the data phase of an internal access
  p_int_strobe_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (int_we || int_re) |=> rsp_valid);
  // R11: enabled and idle leaves the shared port released
  p_idle_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && req_ready) |-> (ad_oe == '0) && ctl_o[1] && ctl_o[2] && !ctl_o[0]);

endmodule

// File: tb/xbus_ctrl_tb.sv
module xbus_ctrl_tb;

  localparam int          AW       = 16;
  localparam int          DW       = 8;
  localparam int unsigned INT_LAST = 32'h10FF;

  logic clk = 1'b0;
  logic rst_n;
  logic en;
  logic req_valid, req_we;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [15:0] int_addr;
  logic [7:0]  int_wdata, int_rdata;
  logic int_we, int_re;
  logic [7:0]  ad_i, ad_o, ad_oe, ad_pu;
  logic [7:0]  ah_o, ah_oe;
  logic [2:0]  ctl_o, ctl_oe;
  logic [7:0]  port_ad_val, port_ad_dir, port_ah_val, port_ah_dir;
  logic [2:0]  port_ctl_val, port_ctl_dir;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  xbus_ctrl #(.AW(AW), .DW(DW), .INT_LAST(INT_LAST)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .int_addr(int_addr), .int_wdata(int_wdata), .int_we(int_we), .int_re(int_re),
    .int_rdata(int_rdata), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe), .ad_pu(ad_pu),
    .ah_o(ah_o), .ah_oe(ah_oe), .ctl_o(ctl_o), .ctl_oe(ctl_oe),
    .port_ad_val(port_ad_val), .port_ad_dir(port_ad_dir),
    .port_ah_val(port_ah_val), .port_ah_dir(port_ah_dir),
    .port_ctl_val(port_ctl_val), .port_ctl_dir(port_ctl_dir)
  );

  // ---------------- behavioural stubs ----------------
  logic [7:0] xmem [0:1023];
  logic [7:0] imem [0:255];
  logic [7:0] lat;
  logic [9:0] xidx;

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 7) + 3);
  endfunction

  always_latch begin
    if (en && ctl_o[0]) lat = ad_o;
  end

  assign xidx      = {ah_o[1:0], lat};
  assign ad_i      = (en && !ctl_o[1]) ? xmem[xidx] : 8'h5A;
  assign int_rdata = imem[int_addr[7:0]];

  always @(posedge clk) begin
    if (en && ctl_oe[2] && !ctl_o[2]) xmem[xidx] <= ad_o;
    if (int_we) imem[int_addr[7:0]] <= int_wdata;
  end

  // ---------------- reference memories ----------------
  logic [7:0] refx [0:1023];
  logic [7:0] refi [0:255];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_pins_port(input string tag);
    chk("R8", {tag, " ad_o"},   ad_o,   port_ad_val);
    chk("R8", {tag, " ad_oe"},  ad_oe,  port_ad_dir);
    chk("R8", {tag, " ad_pu"},  ad_pu,  port_ad_val & ~port_ad_dir);
    chk("R8", {tag, " ah_o"},   ah_o,   port_ah_val);
    chk("R8", {tag, " ah_oe"},  ah_oe,  port_ah_dir);
    chk("R8", {tag, " ctl_o"},  ctl_o,  port_ctl_val);
    chk("R8", {tag, " ctl_oe"}, ctl_oe, port_ctl_dir);
  endtask

  task automatic chk_idle();
    chk("R1", "idle ready", req_ready, 1'b1);
    if (en) begin
      chk("R11", "idle ad_oe",  ad_oe,  8'h00);
      chk("R11", "idle ctl_o",  ctl_o,  3'b110);
      chk("R11", "idle ctl_oe", ctl_oe, 3'b111);
      chk("R10", "idle ad_pu",  ad_pu,  port_ad_val);
    end else begin
      chk_pins_port("idle");
    end
  endtask

  // One full access, compared on every cycle against the expected pin picture
  task automatic access(input logic we, input logic [15:0] a, input logic [7:0] d);
    logic ext;
    logic [9:0] xi;
    logic [7:0] exp_rd;
    ext = (32'(a) > INT_LAST);
    xi  = {a[9:8], a[7:0]};
    if (!ext)    exp_rd = refi[a[7:0]];
    else if (en) exp_rd = refx[xi];
    else         exp_rd = 8'h00;

    @(negedge clk);
    chk_idle();
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;

    // cycle 1: ALE high, low address driven
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1", "c1 ready", req_ready, 1'b0);
    chk("R4", "c1 int strobes", {int_we, int_re}, 2'b00);
    if (en) begin
      chk("R1", "c1 ale", ctl_o[0], 1'b1);
      chk("R2", "c1 ad_o", ad_o, a[7:0]);
      chk("R2", "c1 ad_oe", ad_oe, 8'hFF);
      chk("R3", "c1 ah_o", ah_o, a[15:8]);
      chk("R3", "c1 ah_oe", ah_oe, 8'hFF);
      chk("R7", "c1 strobes", ctl_o[2:1], 2'b11);
      chk("R10", "c1 ad_pu", ad_pu, port_ad_val);
    end else chk_pins_port("c1");

    // cycle 2: ALE low, address held
    @(negedge clk);
    chk("R1", "c2 ready", req_ready, 1'b0);
    chk("R4", "c2 int strobes", {int_we, int_re}, 2'b00);
    if (en) begin
      chk("R1", "c2 ale", ctl_o[0], 1'b0);
      chk("R2", "c2 ad_o", ad_o, a[7:0]);
      chk("R2", "c2 ad_oe", ad_oe, 8'hFF);
      chk("R3", "c2 ah_o", ah_o, a[15:8]);
      chk("R7", "c2 strobes", ctl_o[2:1], 2'b11);
    end else chk_pins_port("c2");

    // cycle 3: data phase
    @(negedge clk);
    chk("R1", "c3 ready", req_ready, 1'b0);
    chk("R4", "c3 int_we", int_we, !ext && we);
    chk("R4", "c3 int_re", int_re, !ext && !we);
    if (!en && ext) chk("R9", "c3 no alias", {int_we, int_re}, 2'b00);
    if (en) begin
      chk("R1", "c3 ale", ctl_o[0], 1'b0);
      chk("R3", "c3 ah_o", ah_o, a[15:8]);
      if (ext && we) begin
        chk("R5", "c3 wr_n", ctl_o[2], 1'b0);
        chk("R5", "c3 rd_n", ctl_o[1], 1'b1);
        chk("R5", "c3 ad_o", ad_o, d);
        chk("R5", "c3 ad_oe", ad_oe, 8'hFF);
      end else if (ext) begin
        chk("R6", "c3 rd_n", ctl_o[1], 1'b0);
        chk("R6", "c3 wr_n", ctl_o[2], 1'b1);
        chk("R6", "c3 ad_oe", ad_oe, 8'h00);
      end else begin
        chk("R7", "c3 strobes", ctl_o[2:1], 2'b11);
        chk("R7", "c3 ad_oe", ad_oe, we ? 8'hFF : 8'h00);
        if (we) chk("R7", "c3 ad_o", ad_o, d);
      end
    end else chk_pins_port("c3");

    // response cycle
    @(negedge clk);
    chk("R1", "rsp_valid", rsp_valid, 1'b1);
    chk("R1", "rsp ready", req_ready, 1'b1);
    if (!we) begin
      if (!ext)      chk("R7", "int rdata", rsp_rdata, exp_rd);
      else if (en)   chk("R6", "ext rdata", rsp_rdata, exp_rd);
      else           chk("R9", "unmapped rdata", rsp_rdata, exp_rd);
    end
    if (we) begin
      if (!ext) refi[a[7:0]] = d;
      else if (en) refx[xi] = d;
    end

    @(negedge clk);
    chk("R1", "rsp pulse ends", rsp_valid, 1'b0);
  endtask

  // Watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 20000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin xmem[i] = pat(i); refx[i] = pat(i); end
    for (int i = 0; i < 256; i++)  begin imem[i] = pat(i + 5); refi[i] = pat(i + 5); end
    rst_n = 1'b0; en = 1'b0;
    req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    port_ad_val = 8'hC3; port_ad_dir = 8'h0F;
    port_ah_val = 8'h96; port_ah_dir = 8'hF0;
    port_ctl_val = 3'b101; port_ctl_dir = 3'b011;
    repeat (3) @(negedge clk);
    chk("R1", "reset ready", req_ready, 1'b1);
    chk("R1", "reset rsp_valid", rsp_valid, 1'b0);
    chk("R4", "reset int strobes", {int_we, int_re}, 2'b00);
    chk_pins_port("reset");
    rst_n = 1'b1;

    // Enabled: external writes around the boundary and at the top
    @(negedge clk); en = 1'b1;
    access(1'b1, 16'h1100, 8'h3E);
    access(1'b1, 16'hFF3C, 8'hD1);
    access(1'b1, 16'h10FF, 8'h77);
    access(1'b1, 16'h0042, 8'hA9);
    access(1'b0, 16'h1100, 8'h00);
    access(1'b0, 16'hFF3C, 8'h00);
    access(1'b0, 16'h10FF, 8'h00);
    access(1'b0, 16'h0042, 8'h00);
    access(1'b0, 16'h2255, 8'h00);

    // Pull-up rule under another port pattern while enabled
    @(negedge clk); port_ad_val = 8'h5A; port_ad_dir = 8'hFF;
    access(1'b0, 16'h0010, 8'h00);

    // Disabled: pins follow ports, unmapped space untouched
    @(negedge clk); en = 1'b0;
    port_ad_val = 8'h3C; port_ad_dir = 8'h55; port_ctl_val = 3'b010; port_ctl_dir = 3'b110;
    access(1'b1, 16'h2042, 8'h99);
    access(1'b1, 16'h1142, 8'h66);
    access(1'b0, 16'h1142, 8'h00);
    access(1'b0, 16'h0042, 8'h00);
    access(1'b1, 16'h0050, 8'h12);
    access(1'b0, 16'h0050, 8'h00);

    // Re-enabled: external location written while disabled is unchanged
    @(negedge clk); en = 1'b1;
    access(1'b0, 16'h1142, 8'h00);
    access(1'b0, 16'h2042, 8'h00);

    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule